// File: doc/BRIEF.md
# Single-Cycle Integer ALU Instruction Executor

This block executes one 32-bit register-to-register or register-immediate integer instruction per clock. The caller presents an instruction word together with a valid strobe. The block splits the word into its fixed fields and reads its two source registers from a 32 x 32-bit register file. It forms the second operand from either a register or the 16-bit immediate, computes the result and writes it to the destination register on the same rising edge.

The immediate is widened in one of two ways, chosen by the class of the operation. Arithmetic and compare operations sign-extend it. Logical operations zero-extend it. The load-upper form places it in the top half of the word. Shifts take their distance either from the 5-bit amount field of the instruction or from the low five bits of the register named by the rs field, and they always shift the value of the register named by rt. An unknown encoding writes nothing and raises a one-cycle flag. Two combinational read ports let the surrounding logic, or a bench, observe any register.

Top module: `alu_exec_core`

## Requirements
- R1: Register 0 reads as zero on every read port at all times, and an instruction that names it as destination leaves it at zero.
- R2: With opcode [31:26] = 0x00, func [5:0] selects the operation: 0x20 add and 0x21 addu compute Reg[rs] + Reg[rt], and 0x22 sub and 0x23 subu compute Reg[rs] - Reg[rt]. All four wrap modulo 2^32 and raise no exception. The sources are rs [25:21] and rt [20:16], and the destination is rd [15:11].
- R3: The register logical operations are func 0x24 (and), 0x25 (or), 0x26 (xor) and 0x27 (nor, the inverted or). Each combines Reg[rs] with Reg[rt].
- R4: func 0x2A writes 1 to rd when Reg[rs] < Reg[rt] compared as signed values, and 0 otherwise. func 0x2B does the same comparison on unsigned values.
- R5: func 0x00 (sll), 0x02 (srl) and 0x03 (sra) shift Reg[rt] by the shamt field [10:6]. srl fills with zeros and sra fills with copies of bit 31.
- R6: func 0x04 (sllv), 0x06 (srlv) and 0x07 (srav) shift Reg[rt] by the low 5 bits of Reg[rs]. The upper bits of Reg[rs] are ignored.
- R7: Opcodes 0x08 (add), 0x09 (add, unsigned), 0x0A (signed less-than) and 0x0B (unsigned less-than) use the immediate [15:0] sign-extended to 32 bits as the second operand, and write the result to rt [20:16].
- R8: Opcodes 0x0C (and), 0x0D (or) and 0x0E (xor) use the immediate zero-extended to 32 bits and write the result to rt.
- R9: Opcode 0x0F writes the immediate shifted left by 16 (low half zero) into rt.
- R10: A register changes only on a rising edge at which instr_valid is high. The new value is visible on the combinational read ports right after that edge. While instr_valid is low the instruction bus has no effect.
- R11: An opcode or func outside the sets above writes no register. It sets illegal_o high for exactly the one cycle that follows the edge at which it was taken.
- R12: While rst is high (synchronous, active high), illegal_o is low and no register is written, even if instr_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is to be executed at this edge |
| instr_word | input | 32 | Instruction to execute |
| illegal_o | output | 1 | Registered one-cycle flag for an unknown encoding |
| dbg_addr_a | input | 5 | Register index for read port A |
| dbg_data_a | output | 32 | Contents of the register chosen by dbg_addr_a |
| dbg_addr_b | input | 5 | Register index for read port B |
| dbg_data_b | output | 32 | Contents of the register chosen by dbg_addr_b |

## Verification
A corrupt register-file entry or a misrouted write address only shows at the ports when the affected register is read back. That happens either directly on a read port in the cycle after the write, or indirectly when a later instruction uses the register as a source and carries the error into its own destination. Each scenario therefore reads back the destination right after every instruction and also reads back neighbouring registers that must not have changed. A wrong decode of the extension class or of the shift source shows as a wrong value one edge after the instruction. A lost or stretched illegal flag shows on illegal_o in the cycle after the offending word and in the cycle after that.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int FLD_W   = 5;
  localparam int IMM_W   = 16;

  // major opcodes
  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0B;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'h0E;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0F;

  // function codes under OPC_REG
  localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FN_W-1:0] FN_SLLV = 6'h04;
  localparam logic [FN_W-1:0] FN_SRLV = 6'h06;
  localparam logic [FN_W-1:0] FN_SRAV = 6'h07;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_REG, SRC_IMM_SX, SRC_IMM_ZX
  } bsrc_e;

  typedef struct packed {
    alu_op_e          op;
    bsrc_e            bsrc;
    logic             shift_var;
    logic [FLD_W-1:0] dest;
    logic             legal;
  } dec_t;

endpackage

// File: rtl/alu_exec_decode.sv
module alu_exec_decode
  import alu_exec_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  input  logic [FN_W-1:0]  fn_i,
  input  logic [FLD_W-1:0] rt_i,
  input  logic [FLD_W-1:0] rd_i,
  output dec_t             dec_o
);

  always_comb begin
    dec_o.op        = ALU_ADD;
    dec_o.bsrc      = SRC_REG;
    dec_o.shift_var = 1'b0;
    dec_o.dest      = rd_i;
    dec_o.legal     = 1'b1;
    case (opc_i)
      OPC_REG: begin
        case (fn_i)
          FN_ADD, FN_ADDU: dec_o.op = ALU_ADD;
          FN_SUB, FN_SUBU: dec_o.op = ALU_SUB;
          FN_AND:          dec_o.op = ALU_AND;
          FN_OR:           dec_o.op = ALU_OR;
          FN_XOR:          dec_o.op = ALU_XOR;
          FN_NOR:          dec_o.op = ALU_NOR;
          FN_SLT:          dec_o.op = ALU_SLT;
          FN_SLTU:         dec_o.op = ALU_SLTU;
          FN_SLL:          dec_o.op = ALU_SLL;
          FN_SRL:          dec_o.op = ALU_SRL;
          FN_SRA:          dec_o.op = ALU_SRA;
          FN_SLLV: begin
            dec_o.op        = ALU_SLL;
            dec_o.shift_var = 1'b1;
          end
          FN_SRLV: begin
            dec_o.op        = ALU_SRL;
            dec_o.shift_var = 1'b1;
          end
          FN_SRAV: begin
            dec_o.op        = ALU_SRA;
            dec_o.shift_var = 1'b1;
          end
          default: dec_o.legal = 1'b0;
        endcase
      end
      OPC_ADDI, OPC_ADDIU: begin
        dec_o.op   = ALU_ADD;
        dec_o.bsrc = SRC_IMM_SX;
        dec_o.dest = rt_i;
      end
      OPC_SLTI: begin
        dec_o.op   = ALU_SLT;
        dec_o.bsrc = SRC_IMM_SX;
        dec_o.dest = rt_i;
      end
      OPC_SLTIU: begin
        dec_o.op   = ALU_SLTU;
        dec_o.bsrc = SRC_IMM_SX;
        dec_o.dest = rt_i;
      end
      OPC_ANDI: begin
        dec_o.op   = ALU_AND;
        dec_o.bsrc = SRC_IMM_ZX;
        dec_o.dest = rt_i;
      end
      OPC_ORI: begin
        dec_o.op   = ALU_OR;
        dec_o.bsrc = SRC_IMM_ZX;
        dec_o.dest = rt_i;
      end
      OPC_XORI: begin
        dec_o.op   = ALU_XOR;
        dec_o.bsrc = SRC_IMM_ZX;
        dec_o.dest = rt_i;
      end
      OPC_LUI: begin
        dec_o.op   = ALU_LUI;
        dec_o.bsrc = SRC_IMM_ZX;
        dec_o.dest = rt_i;
      end
      default: dec_o.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_exec_alu.sv
module alu_exec_alu
  import alu_exec_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
)(
  input  alu_op_e          op_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [SHW-1:0]   shamt_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  result_o
);

  logic [2*IMM_W-1:0] upper_imm;
  assign upper_imm = {imm_i, {IMM_W{1'b0}}};

  always_comb begin
    case (op_i)
      ALU_ADD:  result_o = a_i + b_i;
      ALU_SUB:  result_o = a_i - b_i;
      ALU_AND:  result_o = a_i & b_i;
      ALU_OR:   result_o = a_i | b_i;
      ALU_XOR:  result_o = a_i ^ b_i;
      ALU_NOR:  result_o = ~(a_i | b_i);
      ALU_SLT:  result_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      ALU_SLTU: result_o = {{(XLEN-1){1'b0}}, (a_i < b_i)};
      ALU_SLL:  result_o = b_i << shamt_i;
      ALU_SRL:  result_o = b_i >> shamt_i;
      ALU_SRA:  result_o = $signed(b_i) >>> shamt_i;
      ALU_LUI:  result_o = XLEN'(upper_imm);
      default:  result_o = '0;
    endcase

    if (op_i == ALU_SLT || op_i == ALU_SLTU)
      AST_CMP_IS_BOOLEAN: assert (result_o[XLEN-1:1] == '0); // R4
    if (op_i == ALU_LUI)
      AST_LUI_LOW_CLEAR: assert (result_o[IMM_W-1:0] == '0); // R9
    if (op_i == ALU_SRA)
      AST_SRA_KEEPS_SIGN: assert (result_o[XLEN-1] == b_i[XLEN-1]); // R5
  end

endmodule

// File: rtl/alu_exec_regfile.sv
module alu_exec_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  parameter int NRP   = 4,
  localparam int AW   = $clog2(NREGS)
)(
  input  logic                     clk,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [XLEN-1:0]          wdata_i,
  input  logic [NRP-1:0][AW-1:0]   raddr_i,
  output logic [NRP-1:0][XLEN-1:0] rdata_o
);

  logic [XLEN-1:0] mem [NREGS];

  // entry 0 is never stored; it is forced to zero on read
  always_ff @(posedge clk) begin
    if (we_i && (waddr_i != '0))
      mem[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < NRP; g++) begin : g_rd
    assign rdata_o[g] = (raddr_i[g] == '0) ? '0 : mem[raddr_i[g]];
  end

endmodule

// File: rtl/alu_exec_core.sv
module alu_exec_core
  import alu_exec_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS),
  localparam int SHW  = $clog2(XLEN),
  localparam int NRP  = 4
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr_word,
  output logic               illegal_o,
  input  logic [AW-1:0]      dbg_addr_a,
  output logic [XLEN-1:0]    dbg_data_a,
  input  logic [AW-1:0]      dbg_addr_b,
  output logic [XLEN-1:0]    dbg_data_b
);

  // fixed field positions of the instruction word
  logic [OPC_W-1:0] f_opc;
  logic [FLD_W-1:0] f_rs, f_rt, f_rd;
  logic [SHW-1:0]   f_shamt;
  logic [FN_W-1:0]  f_fn;
  logic [IMM_W-1:0] f_imm;

  assign f_opc   = instr_word[26 +: OPC_W];
  assign f_rs    = instr_word[21 +: FLD_W];
  assign f_rt    = instr_word[16 +: FLD_W];
  assign f_rd    = instr_word[11 +: FLD_W];
  assign f_shamt = instr_word[6 +: SHW];
  assign f_fn    = instr_word[0 +: FN_W];
  assign f_imm   = instr_word[0 +: IMM_W];

  dec_t dec;

  alu_exec_decode u_dec (
    .opc_i (f_opc),
    .fn_i  (f_fn),
    .rt_i  (f_rt),
    .rd_i  (f_rd),
    .dec_o (dec)
  );

  // register file: ports 0/1 feed the datapath, 2/3 are observation
  logic [NRP-1:0][AW-1:0]   rf_raddr;
  logic [NRP-1:0][XLEN-1:0] rf_rdata;
  logic                     rf_we;
  logic [AW-1:0]            rf_waddr;
  logic [XLEN-1:0]          rf_wdata;

  assign rf_raddr = {dbg_addr_b, dbg_addr_a, f_rt[AW-1:0], f_rs[AW-1:0]};

  alu_exec_regfile #(
    .XLEN  (XLEN),
    .NREGS (NREGS),
    .NRP   (NRP)
  ) u_rf (
    .clk     (clk),
    .we_i    (rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata)
  );

  logic [XLEN-1:0] rs_val, rt_val;
  assign rs_val     = rf_rdata[0];
  assign rt_val     = rf_rdata[1];
  assign dbg_data_a = rf_rdata[2];
  assign dbg_data_b = rf_rdata[3];

  // second operand and shift distance
  logic [XLEN-1:0] imm_sx, imm_zx, opnd_b;
  logic [SHW-1:0]  shift_dist;

  assign imm_sx = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
  assign imm_zx = {{(XLEN-IMM_W){1'b0}}, f_imm};

  always_comb begin
    case (dec.bsrc)
      SRC_IMM_SX: opnd_b = imm_sx;
      SRC_IMM_ZX: opnd_b = imm_zx;
      default:    opnd_b = rt_val;
    endcase
  end

  assign shift_dist = dec.shift_var ? rs_val[SHW-1:0] : f_shamt;

  alu_exec_alu #(
    .XLEN (XLEN)
  ) u_alu (
    .op_i     (dec.op),
    .a_i      (rs_val),
    .b_i      (opnd_b),
    .shamt_i  (shift_dist),
    .imm_i    (f_imm),
    .result_o (rf_wdata)
  );

  assign rf_we    = instr_valid && dec.legal && !rst;
  assign rf_waddr = dec.dest[AW-1:0];

  // one-cycle flag for unknown encodings
  logic illegal_q;

  always_ff @(posedge clk) begin
    if (rst)
      illegal_q <= 1'b0;
    else
      illegal_q <= instr_valid && !dec.legal;
  end

  assign illegal_o = illegal_q;

  AST_ILLEGAL_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> $past(instr_valid)); // R11

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
    ($past(rf_we) && ($past(rf_waddr) != '0) && (dbg_addr_a == $past(rf_waddr)))
    |-> (dbg_data_a == $past(rf_wdata))); // R10

endmodule

// File: tb/test_alu_exec_core.sv
module test_alu_exec_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        illegal_o;
  logic [4:0]  dbg_addr_a = '0;
  logic [31:0] dbg_data_a;
  logic [4:0]  dbg_addr_b = '0;
  logic [31:0] dbg_data_b;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  alu_exec_core i_alu_exec_core (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .illegal_o   (illegal_o),
    .dbg_addr_a  (dbg_addr_a),
    .dbg_data_a  (dbg_data_a),
    .dbg_addr_b  (dbg_addr_b),
    .dbg_data_b  (dbg_data_b)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [4:0] sh,
                                        input logic [5:0] fn);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_reg(input string tag, input logic [4:0] r, input logic [31:0] exp);
    dbg_addr_a = r;
    #1;
    chk(tag, dbg_data_a, exp);
  endtask

  // called at a falling edge; returns at the falling edge after the write
  task automatic exec(input logic [31:0] w);
    instr_word  = w;
    instr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic load(input logic [4:0] r, input logic [31:0] v);
    exec(enc_i(6'h0F, 5'd0, r, v[31:16]));
    exec(enc_i(6'h0D, r, r, v[15:0]));
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 illegal low in reset", {31'b0, illegal_o}, 32'd0);
    dbg_addr_b = 5'd0;
    #1;
    chk("R1 r0 zero in reset", dbg_data_b, 32'd0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_zero_reg;
    exec(enc_i(6'h0D, 5'd0, 5'd0, 16'hFFFF));
    dbg_addr_b = 5'd0;
    #1;
    chk("R1 r0 after ori write", dbg_data_b, 32'd0);
    load(5'd7, 32'h1357_9BDF);
    exec(enc_r(5'd7, 5'd7, 5'd0, 5'd0, 6'h20));
    check_reg("R1 r0 after add write", 5'd0, 32'd0);
    exec(enc_r(5'd0, 5'd7, 5'd8, 5'd0, 6'h20));
    check_reg("R1 r0 as source", 5'd8, 32'h1357_9BDF);
  endtask

  task automatic t_arith;
    load(5'd1, 32'h7FFF_FFFF);
    load(5'd2, 32'h0000_0001);
    exec(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h20));
    check_reg("R2 add wrap", 5'd3, 32'h8000_0000);
    exec(enc_r(5'd1, 5'd2, 5'd4, 5'd0, 6'h21));
    check_reg("R2 addu", 5'd4, 32'h8000_0000);
    exec(enc_r(5'd2, 5'd1, 5'd3, 5'd0, 6'h22));
    check_reg("R2 sub", 5'd3, 32'h8000_0002);
    exec(enc_r(5'd0, 5'd2, 5'd4, 5'd0, 6'h23));
    check_reg("R2 subu borrow", 5'd4, 32'hFFFF_FFFF);
    check_reg("R2 source kept", 5'd1, 32'h7FFF_FFFF);
  endtask

  task automatic t_logic;
    load(5'd1, 32'hF0F0_1234);
    load(5'd2, 32'h0FF0_FF00);
    exec(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h24));
    check_reg("R3 and", 5'd3, 32'h00F0_1200);
    exec(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h25));
    check_reg("R3 or", 5'd3, 32'hFFF0_FF34);
    exec(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h26));
    check_reg("R3 xor", 5'd3, 32'hFF00_ED34);
    exec(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h27));
    check_reg("R3 nor", 5'd3, 32'h000F_00CB);
  endtask

  task automatic t_compare;
    load(5'd1, 32'hFFFF_FFFF);
    load(5'd2, 32'h0000_0001);
    exec(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h2A));
    check_reg("R4 slt -1<1", 5'd3, 32'd1);
    exec(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h2B));
    check_reg("R4 sltu big<1", 5'd3, 32'd0);
    exec(enc_r(5'd2, 5'd1, 5'd3, 5'd0, 6'h2A));
    check_reg("R4 slt 1<-1", 5'd3, 32'd0);
    exec(enc_r(5'd2, 5'd1, 5'd3, 5'd0, 6'h2B));
    check_reg("R4 sltu 1<big", 5'd3, 32'd1);
    exec(enc_r(5'd2, 5'd2, 5'd3, 5'd0, 6'h2A));
    check_reg("R4 slt equal", 5'd3, 32'd0);
  endtask

  task automatic t_fixed_shift;
    load(5'd2, 32'h8000_00F1);
    exec(enc_r(5'd0, 5'd2, 5'd3, 5'd4, 6'h00));
    check_reg("R5 sll 4", 5'd3, 32'h0000_0F10);
    exec(enc_r(5'd0, 5'd2, 5'd3, 5'd4, 6'h02));
    check_reg("R5 srl 4", 5'd3, 32'h0800_000F);
    exec(enc_r(5'd0, 5'd2, 5'd3, 5'd4, 6'h03));
    check_reg("R5 sra 4", 5'd3, 32'hF800_000F);
    exec(enc_r(5'd0, 5'd2, 5'd3, 5'd0, 6'h00));
    check_reg("R5 sll 0", 5'd3, 32'h8000_00F1);
    exec(enc_r(5'd0, 5'd2, 5'd3, 5'd31, 6'h02));
    check_reg("R5 srl 31", 5'd3, 32'h0000_0001);
  endtask

  task automatic t_var_shift;
    load(5'd2, 32'h8000_00F1);
    load(5'd1, 32'h0000_0024);
    exec(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h04));
    check_reg("R6 sllv masked", 5'd3, 32'h0000_0F10);
    exec(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h06));
    check_reg("R6 srlv masked", 5'd3, 32'h0800_000F);
    exec(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h07));
    check_reg("R6 srav masked", 5'd3, 32'hF800_000F);
    load(5'd1, 32'h0000_001F);
    exec(enc_r(5'd1, 5'd2, 5'd3, 5'd9, 6'h07));
    check_reg("R6 srav 31 ignores shamt", 5'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_imm_arith;
    load(5'd1, 32'h0000_0005);
    exec(enc_i(6'h08, 5'd1, 5'd3, 16'hFFFD));
    check_reg("R7 addi -3", 5'd3, 32'h0000_0002);
    exec(enc_i(6'h09, 5'd1, 5'd3, 16'h8000));
    check_reg("R7 addiu sign ext", 5'd3, 32'hFFFF_8005);
    exec(enc_i(6'h0A, 5'd1, 5'd3, 16'hFFFF));
    check_reg("R7 slti 5<-1", 5'd3, 32'd0);
    exec(enc_i(6'h0A, 5'd1, 5'd3, 16'h0006));
    check_reg("R7 slti 5<6", 5'd3, 32'd1);
    exec(enc_i(6'h0B, 5'd1, 5'd3, 16'hFFFF));
    check_reg("R7 sltiu 5<big", 5'd3, 32'd1);
  endtask

  task automatic t_imm_logic;
    load(5'd1, 32'hFFFF_1234);
    exec(enc_i(6'h0C, 5'd1, 5'd3, 16'h8F0F));
    check_reg("R8 andi zero ext", 5'd3, 32'h0000_0204);
    exec(enc_i(6'h0D, 5'd1, 5'd3, 16'h8000));
    check_reg("R8 ori", 5'd3, 32'hFFFF_9234);
    exec(enc_i(6'h0E, 5'd1, 5'd3, 16'hFFFF));
    check_reg("R8 xori", 5'd3, 32'hFFFF_EDCB);
  endtask

  task automatic t_upper;
    load(5'd3, 32'h1111_1111);
    exec(enc_i(6'h0F, 5'd0, 5'd3, 16'hBEEF));
    check_reg("R9 lui", 5'd3, 32'hBEEF_0000);
  endtask

  task automatic t_valid_gate;
    load(5'd3, 32'h0000_0ABC);
    instr_word  = enc_i(6'h0D, 5'd0, 5'd3, 16'h0077);
    instr_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_reg("R10 no write without valid", 5'd3, 32'h0000_0ABC);
    dbg_addr_b = 5'd3;
    #1;
    chk("R10 port b agrees", dbg_data_b, 32'h0000_0ABC);
  endtask

  task automatic t_illegal;
    load(5'd3, 32'h0000_5A5A);
    exec(32'hFC63_0000);
    chk("R11 bad opcode flag", {31'b0, illegal_o}, 32'd1);
    check_reg("R11 bad opcode no write", 5'd3, 32'h0000_5A5A);
    @(negedge clk);
    chk("R11 flag one cycle", {31'b0, illegal_o}, 32'd0);
    exec(enc_r(5'd3, 5'd3, 5'd3, 5'd0, 6'h01));
    chk("R11 bad func flag", {31'b0, illegal_o}, 32'd1);
    check_reg("R11 bad func no write", 5'd3, 32'h0000_5A5A);
    exec(enc_r(5'd3, 5'd0, 5'd4, 5'd0, 6'h20));
    chk("R11 legal clears flag", {31'b0, illegal_o}, 32'd0);
    check_reg("R11 legal after illegal", 5'd4, 32'h0000_5A5A);
  endtask

  task automatic t_reset_block;
    load(5'd5, 32'h0000_00AA);
    rst         = 1'b1;
    instr_valid = 1'b1;
    instr_word  = enc_i(6'h0D, 5'd0, 5'd5, 16'h0055);
    @(posedge clk);
    @(negedge clk);
    instr_word = 32'hFC00_0000;
    @(posedge clk);
    @(negedge clk);
    chk("R12 no flag in reset", {31'b0, illegal_o}, 32'd0);
    instr_valid = 1'b0;
    rst         = 1'b0;
    check_reg("R12 no write in reset", 5'd5, 32'h0000_00AA);
    @(negedge clk);
    chk("R12 flag low after reset", {31'b0, illegal_o}, 32'd0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_zero_reg();
    t_arith();
    t_logic();
    t_compare();
    t_fixed_shift();
    t_var_shift();
    t_imm_arith();
    t_imm_logic();
    t_upper();
    t_valid_gate();
    t_illegal();
    t_reset_block();
    summary();
  end

endmodule